// File: doc/BRIEF.md
# Bus Response Timeout Monitor

This block watches every processor bus cycle and raises a one-clock internal bus error when the cycle is not acknowledged in time. In a normal data cycle it waits for the data-size acknowledge. In an interrupt acknowledge cycle it waits for the autovector acknowledge. The time allowed is chosen by a two-bit code and can be 8, 16, 32 or 64 clocks. The error is for internal use only; the block has no path that drives it onto the external bus.

Cycles that target the external bus are timed only when the external-monitor bit is set. A freeze input, together with a freeze-enable bit, suspends timing while the system is halted for debug. A separate check catches spurious interrupt acknowledges. If an interrupt acknowledge cycle starts and no interrupt source wins arbitration, the error fires at once. No configuration bit can switch this check off.

Top module: `bus_resp_monitor`

## Requirements
- R1: After reset, `berr_int` is 0.
- R2: The timing window counts the rising clock edges at which `cyc_strobe` is sampled high, starting with the first one. With `tmo_sel` at 2'b00, 2'b01, 2'b10 or 2'b11, `berr_int` is high in the clock that follows edge 64, 32, 16 or 8 of an unacknowledged cycle.
- R3: In a normal cycle (`cyc_iack` = 0), `dsack` sampled high at any edge up to and including the limit edge ends timing, and no error follows for the rest of that cycle.
- R4: In an interrupt acknowledge cycle (`cyc_iack` = 1), only `avec` ends timing; `dsack` has no effect on the timeout.
- R5: A cycle with `cyc_ext` = 1 is timed only while `ext_mon_en` = 1; otherwise it never times out.
- R6: When an interrupt acknowledge cycle starts with `arb_hit` = 0 at its first edge, `berr_int` is high in the clock after that edge, whatever the values of `tmo_sel`, `ext_mon_en`, `frz_mon_en` and `cyc_ext`.
- R7: While `freeze` = 1 and `frz_mon_en` = 1, strobe-high edges are not counted, so the error moves later by the number of frozen edges. With `frz_mon_en` = 0, `freeze` has no effect.
- R8: Each cycle produces at most one `berr_int` pulse, one clock wide, however long `cyc_strobe` stays high.
- R9: `berr_int` is never raised in a clock that follows an edge where `cyc_strobe` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_strobe | input | 1 | High for the whole of a bus cycle; a rising edge starts a new cycle |
| cyc_iack | input | 1 | 1 = interrupt acknowledge cycle, 0 = normal cycle |
| cyc_ext | input | 1 | 1 = the cycle targets the external bus |
| dsack | input | 1 | Data-size acknowledge |
| avec | input | 1 | Autovector acknowledge |
| arb_hit | input | 1 | An interrupt source won arbitration (sampled at the cycle's first edge) |
| freeze | input | 1 | Debug freeze request |
| tmo_sel | input | 2 | Timeout code: 00=64, 01=32, 10=16, 11=8 clocks |
| ext_mon_en | input | 1 | Enables timing of external-bus cycles |
| frz_mon_en | input | 1 | Lets freeze suspend timing |
| berr_int | output | 1 | One-clock internal bus error pulse |

## Verification
The assertions assume that `cyc_strobe` is low while reset is applied and in the first clock after it, so that their own view of a cycle start matches the block's. They also assume that `cyc_iack`, `cyc_ext` and the configuration bits stay constant while a cycle runs. The bench changes these inputs only while the strobe is low, with at least one idle edge between cycles. Acknowledge and freeze are driven as pulses or windows at chosen edge numbers inside a cycle. This places every boundary edge exactly where the arithmetic expects it.

// File: rtl/bmon_pkg.sv
package bmon_pkg;

   typedef enum logic [1:0] {
      TMO_X8  = 2'b00,
      TMO_X4  = 2'b01,
      TMO_X2  = 2'b10,
      TMO_X1  = 2'b11
   } tmo_code_e;

   // Window length for a code: the shortest window scaled up by 2^(3-code).
   function automatic int unsigned tmo_limit(input logic [1:0] code,
                                             input int unsigned shortest);
      return shortest << (3 - int'(code));
   endfunction

endpackage

// File: rtl/bmon_cycle_track.sv
module bmon_cycle_track (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe,
   input  logic ended,
   output logic start,
   output logic armed
);

   logic strobe_q;
   logic closed_q;

   assign start = strobe & ~strobe_q;
   assign armed = start | ~closed_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         strobe_q <= 1'b0;
         closed_q <= 1'b0;
      end else begin
         strobe_q <= strobe;
         closed_q <= strobe & (ended | (~start & closed_q));
      end
   end

endmodule

// File: rtl/bmon_counter.sv
module bmon_counter #(
   parameter int unsigned CW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          strobe,
   input  logic          start,
   input  logic          ack,
   input  logic          run,
   input  logic          armed,
   input  logic [CW-1:0] limit,
   output logic          hit
);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] base;
   logic [CW-1:0] cnt_nxt;

   always_comb begin
      base = start ? '0 : cnt_q;
      if (!strobe || ack)
         cnt_nxt = '0;
      else if (run && armed)
         cnt_nxt = base + 1'b1;
      else
         cnt_nxt = base;
   end

   assign hit = strobe & ~ack & run & armed & (cnt_nxt == limit);

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_nxt;
   end

endmodule

// File: rtl/bus_resp_monitor.sv
module bus_resp_monitor #(
   parameter int unsigned SHORTEST_TMO   = 8,
   parameter bit          FREEZE_SUPPORT = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cyc_strobe,
   input  logic       cyc_iack,
   input  logic       cyc_ext,
   input  logic       dsack,
   input  logic       avec,
   input  logic       arb_hit,
   input  logic       freeze,
   input  logic [1:0] tmo_sel,
   input  logic       ext_mon_en,
   input  logic       frz_mon_en,
   output logic       berr_int
);
   import bmon_pkg::*;

   localparam int unsigned LONGEST_TMO = SHORTEST_TMO * 8;
   localparam int unsigned CW          = $clog2(LONGEST_TMO + 1);

   if (SHORTEST_TMO < 2 || (SHORTEST_TMO & (SHORTEST_TMO - 1)) != 0) begin : g_bad_tmo
      $error("SHORTEST_TMO must be a power of two of at least 2");
   end

   logic          start;
   logic          armed;
   logic          ack_sel;
   logic          target_ok;
   logic          frozen;
   logic          run;
   logic          spurious;
   logic          hit;
   logic [CW-1:0] limit;

   assign limit = CW'(tmo_limit(tmo_sel, SHORTEST_TMO));

   if (FREEZE_SUPPORT) begin : g_frz
      assign frozen = freeze & frz_mon_en;
   end else begin : g_nofrz
      logic unused_frz;
      assign unused_frz = freeze ^ frz_mon_en;
      assign frozen     = 1'b0;
   end

   assign ack_sel   = cyc_iack ? avec : dsack;
   assign target_ok = ~cyc_ext | ext_mon_en;
   assign run       = cyc_strobe & target_ok & ~frozen;
   assign spurious  = start & cyc_iack & ~arb_hit;

   bmon_cycle_track u_track (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobe (cyc_strobe),
      .ended  (ack_sel | spurious | hit),
      .start  (start),
      .armed  (armed)
   );

   bmon_counter #(.CW(CW)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobe (cyc_strobe),
      .start  (start),
      .ack    (ack_sel | spurious),
      .run    (run),
      .armed  (armed),
      .limit  (limit),
      .hit    (hit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) berr_int <= 1'b0;
      else        berr_int <= spurious | hit;
   end

endmodule

// File: rtl/bmon_checker.sv
module bmon_checker (
   input logic clk,
   input logic rst_n,
   input logic cyc_strobe,
   input logic cyc_iack,
   input logic cyc_ext,
   input logic dsack,
   input logic arb_hit,
   input logic freeze,
   input logic ext_mon_en,
   input logic frz_mon_en,
   input logic berr_int
);

   // R8: never two pulses back to back
   a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      berr_int |=> !berr_int);

   // R9: an error always follows a strobe-high edge
   a_r9_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !cyc_strobe |=> !berr_int);

   // R3: acknowledged normal cycle gives no error next clock
   a_r3_ack_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_strobe && !cyc_iack && dsack) |=> !berr_int);

   // R5: unmonitored external normal cycle never errs
   a_r5_ext_off: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_strobe && !cyc_iack && cyc_ext && !ext_mon_en) |=> !berr_int);

   // R7: frozen normal cycle edge cannot raise an error
   a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_strobe && !cyc_iack && freeze && frz_mon_en) |=> !berr_int);

   // R6: spurious interrupt acknowledge errs at once
   a_r6_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cyc_strobe) && cyc_iack && !arb_hit) |=> berr_int);

endmodule

bind bus_resp_monitor bmon_checker u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cyc_strobe (cyc_strobe),
   .cyc_iack   (cyc_iack),
   .cyc_ext    (cyc_ext),
   .dsack      (dsack),
   .arb_hit    (arb_hit),
   .freeze     (freeze),
   .ext_mon_en (ext_mon_en),
   .frz_mon_en (frz_mon_en),
   .berr_int   (berr_int)
);

// File: tb/bus_resp_monitor_tb.sv
module bus_resp_monitor_tb;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cyc_strobe = 1'b0;
   logic       cyc_iack = 1'b0;
   logic       cyc_ext = 1'b0;
   logic       dsack = 1'b0;
   logic       avec = 1'b0;
   logic       arb_hit = 1'b0;
   logic       freeze = 1'b0;
   logic [1:0] tmo_sel = 2'b00;
   logic       ext_mon_en = 1'b0;
   logic       frz_mon_en = 1'b0;
   logic       berr_int;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bus_resp_monitor u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .cyc_strobe (cyc_strobe),
      .cyc_iack   (cyc_iack),
      .cyc_ext    (cyc_ext),
      .dsack      (dsack),
      .avec       (avec),
      .arb_hit    (arb_hit),
      .freeze     (freeze),
      .tmo_sel    (tmo_sel),
      .ext_mon_en (ext_mon_en),
      .frz_mon_en (frz_mon_en),
      .berr_int   (berr_int)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Runs one cycle of 'total' strobe-high edges; edge numbers start at 1.
   task automatic run_cyc(input logic iack, input logic ext, input logic arb,
                          input int ds_e, input int av_e,
                          input int frz_f, input int frz_l, input int total,
                          output int first, output int pulses);
      first  = 0;
      pulses = 0;
      @(negedge clk);
      cyc_strobe = 1'b1;
      cyc_iack   = iack;
      cyc_ext    = ext;
      arb_hit    = arb;
      for (int e = 1; e <= total; e++) begin
         dsack  = (e == ds_e);
         avec   = (e == av_e);
         freeze = (e >= frz_f) && (e < frz_f + frz_l);
         @(posedge clk);
         @(negedge clk);
         if (berr_int) begin
            pulses++;
            if (first == 0) first = e;
         end
      end
      cyc_strobe = 1'b0;
      dsack = 1'b0; avec = 1'b0; freeze = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk(berr_int == 1'b0, "R9 after strobe low", int'(berr_int), 0);
      cyc_iack = 1'b0; cyc_ext = 1'b0; arb_hit = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int f;
      int p;
      int lim;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk(berr_int == 1'b0, "R1 reset state", int'(berr_int), 0);

      // R2 / R8: every timeout code, unacknowledged normal internal cycle
      for (int s = 0; s < 4; s++) begin
         tmo_sel = 2'(s);
         lim = 64 >> s;
         run_cyc(1'b0, 1'b0, 1'b1, 0, 0, 0, 0, lim + 4, f, p);
         chk(f == lim, "R2 timeout edge", f, lim);
         chk(p == 1, "R8 one pulse", p, 1);
      end

      // R3: acknowledge before and at the limit edge, then strobe held long
      tmo_sel = 2'b11;
      run_cyc(1'b0, 1'b0, 1'b1, 7, 0, 0, 0, 12, f, p);
      chk(p == 0, "R3 ack at edge 7", p, 0);
      run_cyc(1'b0, 1'b0, 1'b1, 8, 0, 0, 0, 12, f, p);
      chk(p == 0, "R3 ack at limit edge", p, 0);
      run_cyc(1'b0, 1'b0, 1'b1, 3, 0, 0, 0, 30, f, p);
      chk(p == 0, "R3 ack then long hold", p, 0);

      // R4: interrupt acknowledge uses avec, dsack ignored
      run_cyc(1'b1, 1'b0, 1'b1, 0, 5, 0, 0, 12, f, p);
      chk(p == 0, "R4 avec ends timing", p, 0);
      run_cyc(1'b1, 1'b0, 1'b1, 5, 0, 0, 0, 12, f, p);
      chk(f == 8, "R4 dsack ignored in iack", f, 8);

      // R5: external cycles gated by ext_mon_en
      tmo_sel = 2'b00;
      run_cyc(1'b0, 1'b1, 1'b1, 0, 0, 0, 0, 80, f, p);
      chk(p == 0, "R5 external unmonitored", p, 0);
      tmo_sel = 2'b10; ext_mon_en = 1'b1;
      run_cyc(1'b0, 1'b1, 1'b1, 0, 0, 0, 0, 20, f, p);
      chk(f == 16, "R5 external monitored", f, 16);
      ext_mon_en = 1'b0;

      // R6: spurious interrupt acknowledge
      tmo_sel = 2'b00;
      run_cyc(1'b1, 1'b0, 1'b0, 0, 0, 0, 0, 70, f, p);
      chk(f == 1, "R6 spurious first edge", f, 1);
      chk(p == 1, "R6 spurious single pulse", p, 1);
      frz_mon_en = 1'b1;
      run_cyc(1'b1, 1'b1, 1'b0, 0, 0, 1, 5, 10, f, p);
      chk(f == 1, "R6 spurious ext and frozen", f, 1);

      // R7: freeze window of 5 edges starting at edge 3
      tmo_sel = 2'b11;
      run_cyc(1'b0, 1'b0, 1'b1, 0, 0, 3, 5, 20, f, p);
      chk(f == 13, "R7 frozen shift", f, 13);
      frz_mon_en = 1'b0;
      run_cyc(1'b0, 1'b0, 1'b1, 0, 0, 3, 5, 20, f, p);
      chk(f == 8, "R7 freeze disabled", f, 8);

      // R8: strobe held far past the limit
      run_cyc(1'b0, 1'b0, 1'b1, 0, 0, 0, 0, 200, f, p);
      chk(p == 1, "R8 long hold single pulse", p, 1);

      // R9: idle bus with acknowledges toggling
      p = 0;
      for (int i = 0; i < 100; i++) begin
         dsack = i[0]; avec = i[1];
         @(posedge clk);
         @(negedge clk);
         if (berr_int) p++;
      end
      dsack = 1'b0; avec = 1'b0;
      chk(p == 0, "R9 idle bus", p, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule